// File: doc/BRIEF.md
# Cubic Fractional-Delay Resampler

This block accepts one signed sample per clock and emits a stream at a lower rate. The output rate is set by a fixed-point phase step. Every clock, a phase accumulator moves the output instant forward relative to the input grid. Each output is a cubic polynomial evaluated at fraction `t`. The polynomial is fitted over four neighbouring input samples.

A run-time select picks the kernel. One choice is the interpolating Lagrange cubic. The other is a Hermite cubic whose end slopes come from central differences. When the accumulator passes unity, that cycle yields no sample and the phase drops by one. The output sequence therefore keeps a steady, possibly non-rational, spacing. A valid strobe marks every clock that carries a resampled value.

The phase step is captured only while `run` is low. Raising `run` starts a fresh window fill with the phase at zero.

Top module: `frac_cubic_resampler`

## Requirements
- R1: While reset is asserted, `out_valid` and `out_data` are both zero.
- R2: If `run` is high at the first of a series of rising edges, the first `out_valid` pulse is seen right after the sixth of those edges. Four edges fill the window and two are pipeline stages.
- R3: Call the sample captured at the first edge with `run` high index 0. Output number j (counting from 0) then uses base index n = 1 + j + floor(j·inc/65536) and fraction t = (j·inc mod 65536)/65536. Here `inc` is the 16-bit step, an unsigned value with 16 fractional bits. Outputs leave the block in order.
- R4: With `hermite` = 0, let a, b, c, d be the samples at n−1, n, n+1, n+2. The exact value is b + t(−2a−3b+6c−d)/6 + t²(a−2b+c)/2 + t³(−a+3b−3c+d)/6.
- R5: With `hermite` = 1, the exact value is b + t(c−a)/2 + t²(2a−5b+4c−d)/2 + t³(−a+3b−3c+d)/2.
- R6: The exact value is rounded to the nearest integer, with halves rounded toward +∞. The result is then clamped to the signed `DW`-bit range.
- R7: Each phase overflow costs exactly one invalid cycle. Because the step is below one, two invalid cycles never follow each other while running after the first output. Over a run, the number of outputs matches the count implied by R3.
- R8: `phase_inc` is captured only while `run` is low or in reset. Changes while running do not alter the output sequence.
- R9: With a step of zero, every cycle after the first output is valid, and each output equals sample n exactly.
- R10: After `run` falls, at most one pending output may still appear. From the third clock on, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | High to stream; low idles the block and captures the step |
| hermite | input | 1 | Kernel select: 0 Lagrange cubic, 1 Hermite cubic |
| phase_inc | input | FW | Phase step per clock, unsigned fraction |
| in_data | input | DW | Signed input sample, one per clock |
| out_data | output | DW | Signed resampled value |
| out_valid | output | 1 | High when `out_data` carries a resampled value |

## Verification
Two functions can land on one clock: the phase-overflow skip, and a write to the step input while streaming. The bench provokes this by presenting a different `phase_inc` value on every clock of a run. Every skip cycle therefore coincides with an attempted step change. The run is judged against the closed-form positions of R3 computed with the captured step. A separate test drives full-scale alternating samples so that clamping coincides with fractional positions and skip cycles.

// File: rtl/frac_cubic_resampler.sv
module frac_cubic_resampler #(
  parameter int DW = 16,
  parameter int FW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 hermite,
  input  logic [FW-1:0]        phase_inc,
  input  logic signed [DW-1:0] in_data,
  output logic signed [DW-1:0] out_data,
  output logic                 out_valid
);

  localparam int KW = DW + 7;
  localparam int AW = KW + 3*FW + 3;
  localparam logic [FW:0] ONE = {1'b1, {FW{1'b0}}};
  localparam logic signed [KW-1:0] K2 = KW'(2);
  localparam logic signed [KW-1:0] K3 = KW'(3);
  localparam logic signed [KW-1:0] K4 = KW'(4);
  localparam logic signed [KW-1:0] K5 = KW'(5);
  localparam logic signed [KW-1:0] K6 = KW'(6);
  localparam logic signed [AW-1:0] SIX  = AW'(6);
  localparam logic signed [AW-1:0] HALF = AW'(3) <<< (3*FW);
  localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [DW-1:0] win [4];
  logic [2:0]    cnt;
  logic [FW:0]   acc;
  logic [FW-1:0] inc_r;
  logic full, ovf;

  assign full = (cnt == 3'd4);
  assign ovf  = acc[FW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) win[i] <= '0;
      cnt   <= '0;
      acc   <= '0;
      inc_r <= '0;
    end else begin
      win[0] <= in_data;
      for (int i = 1; i < 4; i++) win[i] <= win[i-1];
      if (!run) begin
        cnt   <= '0;
        acc   <= '0;
        inc_r <= phase_inc;
      end else begin
        if (!full) cnt <= cnt + 3'd1;
        if (full)  acc <= ovf ? acc - ONE : acc + {1'b0, inc_r};
      end
    end
  end

  logic signed [KW-1:0] xa, xb, xc, xd, k1, k2, k3;
  assign xa = KW'(win[3]);
  assign xb = KW'(win[2]);
  assign xc = KW'(win[1]);
  assign xd = KW'(win[0]);

  always_comb begin
    if (hermite) begin
      k1 = K3 * (xc - xa);
      k2 = K3 * (K2*xa - K5*xb + K4*xc - xd);
      k3 = K3 * (K3*xb - xa - K3*xc + xd);
    end else begin
      k1 = K6*xc - K2*xa - K3*xb - xd;
      k2 = K3 * (xa - K2*xb + xc);
      k3 = K3*xb - xa - K3*xc + xd;
    end
  end

  logic signed [KW-1:0] kb0, kb1, kb2, kb3;
  logic [FW-1:0] tb;
  logic vb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kb0 <= '0; kb1 <= '0; kb2 <= '0; kb3 <= '0;
      tb  <= '0;
      vb  <= 1'b0;
    end else begin
      kb0 <= K6 * xb;
      kb1 <= k1;
      kb2 <= k2;
      kb3 <= k3;
      tb  <= acc[FW-1:0];
      vb  <= run & full & ~ovf;
    end
  end

  logic signed [AW-1:0] tt, h2, h1, h0, sh, q, qf, sat;
  assign tt = AW'({1'b0, tb});
  assign h2 = (AW'(kb2) <<< FW)     + AW'(kb3) * tt;
  assign h1 = (AW'(kb1) <<< (2*FW)) + h2 * tt;
  assign h0 = (AW'(kb0) <<< (3*FW)) + h1 * tt;
  assign sh = (h0 + HALF) >>> (3*FW);
  assign q  = sh / SIX;
  assign qf = (sh < 0 && q * SIX != sh) ? q - AW'(1) : q;
  assign sat = (qf > MAXV) ? MAXV : (qf < MINV) ? MINV : qf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_data  <= sat[DW-1:0];
      out_valid <= vb;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_data == '0));

  // R2
  window_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(full, 2));

  // R7
  single_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);

  // R7
  skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ovf) |=> ##1 !out_valid);

  // R8
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != 3'd0) |-> $stable(inc_r));

endmodule

// File: tb/frac_cubic_resampler_test.sv
`timescale 1ns/1ps
module frac_cubic_resampler_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic hermite = 1'b0;
  logic [15:0] phase_inc = '0;
  logic signed [15:0] in_data = '0;
  logic signed [15:0] out_data;
  logic out_valid;

  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  frac_cubic_resampler #(.DW(16), .FW(16)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .hermite(hermite),
    .phase_inc(phase_inc), .in_data(in_data),
    .out_data(out_data), .out_valid(out_valid)
  );

  function automatic int samp(int pat, int k);
    case (pat)
      0: return k*97 - 4000;
      1: return ((k*7919 + k*k*13) % 20011) - 10005;
      default: begin
        case (k % 4)
          0, 3: return -32768;
          default: return 32767;
        endcase
      end
    endcase
  endfunction

  function automatic int expect_val(int pat, bit herm, int j, int inc);
    logic signed [127:0] a, b, c, d, t, k1, k2, k3, num, den, q;
    int n;
    n = 1 + j + (j*inc) / 65536;
    a = 128'(samp(pat, n-1)); b = 128'(samp(pat, n));
    c = 128'(samp(pat, n+1)); d = 128'(samp(pat, n+2));
    t = 128'((j*inc) % 65536);
    if (herm) begin
      k1 = 3*(c - a);
      k2 = 3*(2*a - 5*b + 4*c - d);
      k3 = 3*(-a + 3*b - 3*c + d);
    end else begin
      k1 = -2*a - 3*b + 6*c - d;
      k2 = 3*(a - 2*b + c);
      k3 = -a + 3*b - 3*c + d;
    end
    num = 6*b*(128'(1) << 48) + k1*t*(128'(1) << 32) + k2*t*t*(128'(1) << 16) + k3*t*t*t;
    den = 6*(128'(1) << 48);
    num = num + 3*(128'(1) << 48);
    q = num / den;
    if (num < 0 && q*den != num) q = q - 1;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  task automatic check(string req, int actual, int expected);
    vectors++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 valid", int'(out_valid), 0);
    check("R1 data", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_case(string req, bit herm, int pat, int inc, int ncyc, bit scramble);
    int j = 0;
    int first = -1;
    int gaps = 0;
    int doubles = 0;
    int bad = 0;
    int exp_cnt = 0;
    bit prev_inv = 1'b0;
    run = 1'b0;
    hermite = herm;
    phase_inc = 16'(inc);
    repeat (2) @(negedge clk);
    check("R10 idle", int'(out_valid), 0);
    run = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      if (k > 0) begin
        if (out_valid) begin
          if (first < 0) first = k;
          if (out_data != 16'(expect_val(pat, herm, j, inc))) begin
            bad++;
            if (bad < 4) check({req, " R3 value"}, int'(out_data), expect_val(pat, herm, j, inc));
          end
          j++;
          prev_inv = 1'b0;
        end else if (first >= 0) begin
          gaps++;
          if (prev_inv) doubles++;
          prev_inv = 1'b1;
        end
      end
      in_data = 16'(samp(pat, k));
      if (scramble) phase_inc = 16'((k*12345 + 777) & 16'hFFFF);
      @(negedge clk);
    end
    run = 1'b0;
    for (int f = 0; f < 3; f++) begin
      if (f < 2 && out_valid) begin
        if (out_data != 16'(expect_val(pat, herm, j, inc))) begin
          bad++;
          if (bad < 4) check({req, " R3 tail"}, int'(out_data), expect_val(pat, herm, j, inc));
        end
        j++;
      end
      @(negedge clk);
    end
    check("R10 stopped", int'(out_valid), 0);
    check({req, " all values"}, bad, 0);
    check("R2 first valid", first, 6);
    check("R7 no double skip", doubles, 0);
    for (int m = 0; 1 + m + (m*inc)/65536 <= ncyc - 4; m++) exp_cnt = m + 1;
    check("R7 output count", j, exp_cnt);
    if (inc == 0) check("R9 no gaps", gaps, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    test_reset();
    run_case("R4 ramp", 1'b0, 0, 16'h5000, 120, 1'b0);
    run_case("R4 mixed", 1'b0, 1, 16'h3A7D, 200, 1'b0);
    run_case("R5 mixed", 1'b1, 1, 16'h4E5F, 200, 1'b0);
    run_case("R6 clamp lagrange", 1'b0, 2, 16'h2B3C, 160, 1'b0);
    run_case("R6 clamp hermite", 1'b1, 2, 16'h6D01, 160, 1'b0);
    run_case("R9 unit step", 1'b0, 1, 0, 80, 1'b0);
    run_case("R7 near half rate", 1'b1, 1, 16'hFFFF, 200, 1'b0);
    run_case("R8 step changes", 1'b0, 1, 16'h1234, 200, 1'b1);
    run_case("R8 step changes hermite", 1'b1, 2, 16'hC001, 200, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule